// File: doc/BRIEF.md
# Render-time scroll address stepper

This block computes the next value of the 15-bit current video address while the picture is being drawn. Each clock it takes the present address, the staged address, a rendering-enable flag, the dot number within the scanline and a flag marking the pre-render line. It applies whichever timed update falls on that dot and registers the result. The caller writes that result back into its address register.

The address packs five fields. Bits 4:0 are the coarse horizontal tile index. Bits 9:5 are the coarse vertical tile index. Bit 10 selects the horizontal nametable and bit 11 the vertical nametable. Bits 14:12 are the fine vertical pixel row.

Four timed updates exist:
- A horizontal tile step on the last dot of each 8-dot fetch group inside the two fetch windows.
- A vertical step on one fixed dot.
- A copy of the horizontal fields from the staged address on a later dot.
- A copy of the whole address on one dot of the pre-render line.

When several of these fall on the same dot, they are applied in that order: tile step, vertical step, then copy. The dot counters and the fetch pipeline sit outside the block.

Top module: `scroll_stepper`

## Requirements
- R1: While rst_ni is low, v_o is 0.
- R2: When render_en_i is 0, v_o one clock later equals v_i, whatever the dot and line flags.
- R3: With rendering on, a dot that is a multiple of 8 in 8..256 or in 328..336 increments bits 4:0. On 31 those bits wrap to 0 and bit 10 inverts. A multiple of 8 outside those windows (for example 264 or 320) changes nothing.
- R4: With rendering on, dot 250 increments bits 14:12. Only when those bits roll over from 7 to 0 do bits 9:5 advance. This applies on the pre-render line as well.
- R5: In the vertical step, coarse Y 29 rolls over to 0 and bit 11 inverts.
- R6: In the vertical step, coarse Y 31 rolls over to 0 with bit 11 unchanged, and coarse Y 30 becomes 31.
- R7: With rendering on, dot 256 takes bits 10 and 4:0 from t_i and keeps every other bit of v_i. The copy overrides the tile step on the same dot.
- R8: With rendering on, dot 304 of the pre-render line loads all 15 bits from t_i. On other lines, dot 304 leaves v_i unchanged.
- R9: With rendering on, any dot other than 250, 256 and the pre-render dot 304 keeps bits 14:11 and 9:5 of v_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| render_en_i | input | 1 | Rendering enabled |
| prerender_i | input | 1 | Current line is the pre-render line |
| dot_i | input | 9 | Dot number within the scanline |
| v_i | input | 15 | Present current address |
| t_i | input | 15 | Staged address |
| v_o | output | 15 | Registered next current address |

## Verification
The bench targets the three coarse-Y wrap cases: 29, 30 and 31, each with the vertical nametable bit both clear and set. A design that treats 29 like any other value walks into attribute rows. A design that toggles the nametable on the 31 wrap flips the screen half.

It probes the fetch-window edges at dots 264, 320, 328 and 336. A window test that is off by one either steps the tile outside the fetch region or misses the prefetch steps.

It checks that the dot-256 copy wins over the tile step that lands on the same dot. It also checks that dot 304 copies only on the pre-render line. Getting either wrong corrupts the horizontal scroll or reloads the frame mid-screen.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int VADDR_W = 15;
  localparam int FIELD_W = 5;
  localparam int FINE_W  = 3;

  typedef struct packed {
    logic [FINE_W-1:0]  fine_y;
    logic               nt_v;
    logic               nt_h;
    logic [FIELD_W-1:0] coarse_y;
    logic [FIELD_W-1:0] coarse_x;
  } vaddr_t;
endpackage

// File: rtl/scroll_dot_decode.sv
module scroll_dot_decode #(
  parameter int DOT_W     = 9,
  parameter int TILE_LOG2 = 3,
  parameter int WIN0_LO   = 1,
  parameter int WIN0_HI   = 256,
  parameter int WIN1_LO   = 321,
  parameter int WIN1_HI   = 336,
  parameter int VERT_DOT  = 250,
  parameter int HCOPY_DOT = 256,
  parameter int FCOPY_DOT = 304
) (
  input  logic             render_en_i,
  input  logic             prerender_i,
  input  logic [DOT_W-1:0] dot_i,
  output logic             cx_inc_o,
  output logic             vert_inc_o,
  output logic             hcopy_o,
  output logic             fcopy_o
);
  localparam int NWIN = 2;
  localparam int WIN_LO [NWIN] = '{WIN0_LO, WIN1_LO};
  localparam int WIN_HI [NWIN] = '{WIN0_HI, WIN1_HI};

  logic [NWIN-1:0] win_hit;

  // A window fires on the last dot of each tile group.
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [DOT_W-1:0] ofs;
    logic             in_win;
    assign ofs    = dot_i - DOT_W'(WIN_LO[w]) + DOT_W'(1);
    assign in_win = (dot_i >= DOT_W'(WIN_LO[w])) && (dot_i <= DOT_W'(WIN_HI[w]));
    assign win_hit[w] = in_win && (ofs[TILE_LOG2-1:0] == '0);
  end

  assign cx_inc_o   = render_en_i && (|win_hit);
  assign vert_inc_o = render_en_i && (dot_i == DOT_W'(VERT_DOT));
  assign hcopy_o    = render_en_i && (dot_i == DOT_W'(HCOPY_DOT));
  assign fcopy_o    = render_en_i && prerender_i && (dot_i == DOT_W'(FCOPY_DOT));
endmodule

// File: rtl/scroll_cx_step.sv
module scroll_cx_step
  import scroll_pkg::*;
(
  input  vaddr_t v_i,
  input  logic   inc_i,
  output vaddr_t v_o
);
  always_comb begin
    v_o = v_i;
    if (inc_i) begin
      if (&v_i.coarse_x) begin
        v_o.coarse_x = '0;
        v_o.nt_h     = ~v_i.nt_h;
      end else begin
        v_o.coarse_x = v_i.coarse_x + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scroll_vert_step.sv
module scroll_vert_step
  import scroll_pkg::*;
#(
  parameter int LAST_ROW = 29
) (
  input  vaddr_t v_i,
  input  logic   inc_i,
  output vaddr_t v_o
);
  localparam logic [FIELD_W-1:0] ROW_END = FIELD_W'(LAST_ROW);

  always_comb begin
    v_o = v_i;
    if (inc_i) begin
      if (!(&v_i.fine_y)) begin
        v_o.fine_y = v_i.fine_y + 1'b1;
      end else begin
        v_o.fine_y = '0;
        if (v_i.coarse_y == ROW_END) begin
          v_o.coarse_y = '0;
          v_o.nt_v     = ~v_i.nt_v;
        end else if (&v_i.coarse_y) begin
          v_o.coarse_y = '0;
        end else begin
          v_o.coarse_y = v_i.coarse_y + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scroll_copy.sv
module scroll_copy
  import scroll_pkg::*;
(
  input  vaddr_t v_i,
  input  vaddr_t t_i,
  input  logic   hcopy_i,
  input  logic   fcopy_i,
  output vaddr_t v_o
);
  always_comb begin
    v_o = v_i;
    if (fcopy_i) begin
      v_o = t_i;
    end else if (hcopy_i) begin
      v_o.nt_h     = t_i.nt_h;
      v_o.coarse_x = t_i.coarse_x;
    end
  end
endmodule

// File: rtl/scroll_stepper.sv
module scroll_stepper
  import scroll_pkg::*;
#(
  parameter int DOT_W     = 9,
  parameter int TILE_LOG2 = 3,
  parameter int WIN0_LO   = 1,
  parameter int WIN0_HI   = 256,
  parameter int WIN1_LO   = 321,
  parameter int WIN1_HI   = 336,
  parameter int VERT_DOT  = 250,
  parameter int HCOPY_DOT = 256,
  parameter int FCOPY_DOT = 304,
  parameter int LAST_ROW  = 29
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               render_en_i,
  input  logic               prerender_i,
  input  logic [DOT_W-1:0]   dot_i,
  input  logic [VADDR_W-1:0] v_i,
  input  logic [VADDR_W-1:0] t_i,
  output logic [VADDR_W-1:0] v_o
);
  logic   cx_inc, vert_inc, hcopy, fcopy;
  vaddr_t v_in, t_in, v_cx, v_vert, v_cp, v_q;

  assign v_in = vaddr_t'(v_i);
  assign t_in = vaddr_t'(t_i);

  scroll_dot_decode #(
    .DOT_W(DOT_W), .TILE_LOG2(TILE_LOG2),
    .WIN0_LO(WIN0_LO), .WIN0_HI(WIN0_HI),
    .WIN1_LO(WIN1_LO), .WIN1_HI(WIN1_HI),
    .VERT_DOT(VERT_DOT), .HCOPY_DOT(HCOPY_DOT), .FCOPY_DOT(FCOPY_DOT)
  ) u_decode (
    .render_en_i(render_en_i),
    .prerender_i(prerender_i),
    .dot_i      (dot_i),
    .cx_inc_o   (cx_inc),
    .vert_inc_o (vert_inc),
    .hcopy_o    (hcopy),
    .fcopy_o    (fcopy)
  );

  // Fixed precedence: tile step, vertical step, copy.
  scroll_cx_step u_cx (.v_i(v_in), .inc_i(cx_inc), .v_o(v_cx));

  scroll_vert_step #(.LAST_ROW(LAST_ROW)) u_vert (
    .v_i(v_cx), .inc_i(vert_inc), .v_o(v_vert)
  );

  scroll_copy u_copy (
    .v_i(v_vert), .t_i(t_in), .hcopy_i(hcopy), .fcopy_i(fcopy), .v_o(v_cp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= v_cp;
  end

  assign v_o = v_q;
endmodule

// File: rtl/scroll_stepper_chk.sv
module scroll_stepper_chk #(
  parameter int DOT_W     = 9,
  parameter int VERT_DOT  = 250,
  parameter int HCOPY_DOT = 256,
  parameter int FCOPY_DOT = 304
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             render_en_i,
  input logic             prerender_i,
  input logic [DOT_W-1:0] dot_i,
  input logic [14:0]      v_i,
  input logic [14:0]      t_i,
  input logic [14:0]      v_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> v_o == '0);

  // R2
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(render_en_i) |-> v_o == $past(v_i));

  // R8
  full_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(render_en_i && prerender_i && dot_i == DOT_W'(FCOPY_DOT))
    |-> v_o == $past(t_i));

  // R7
  hcopy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(render_en_i && dot_i == DOT_W'(HCOPY_DOT))
    |-> (v_o[10] == $past(t_i[10])) && (v_o[4:0] == $past(t_i[4:0]))
        && (v_o[14:11] == $past(v_i[14:11])) && (v_o[9:5] == $past(v_i[9:5])));

  // R4
  fine_y_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(render_en_i && dot_i == DOT_W'(VERT_DOT) && v_i[14:12] != 3'd7)
    |-> (v_o[14:12] == $past(v_i[14:12]) + 3'd1) && (v_o[11:5] == $past(v_i[11:5])));

  // R9
  vert_fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(render_en_i) && $past(dot_i) != DOT_W'(VERT_DOT)
    && $past(dot_i) != DOT_W'(HCOPY_DOT)
    && !$past(prerender_i && dot_i == DOT_W'(FCOPY_DOT))
    |-> (v_o[14:11] == $past(v_i[14:11])) && (v_o[9:5] == $past(v_i[9:5])));
endmodule

bind scroll_stepper scroll_stepper_chk #(
  .DOT_W(DOT_W), .VERT_DOT(VERT_DOT), .HCOPY_DOT(HCOPY_DOT), .FCOPY_DOT(FCOPY_DOT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .render_en_i(render_en_i),
  .prerender_i(prerender_i), .dot_i(dot_i), .v_i(v_i), .t_i(t_i), .v_o(v_o)
);

// File: tb/scroll_stepper_tb.sv
`timescale 1ns/1ps
module scroll_stepper_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        render_en_i = 1'b0;
  logic        prerender_i = 1'b0;
  logic [8:0]  dot_i = '0;
  logic [14:0] v_i = '0;
  logic [14:0] t_i = '0;
  logic [14:0] v_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  scroll_stepper u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .render_en_i(render_en_i),
    .prerender_i(prerender_i), .dot_i(dot_i), .v_i(v_i), .t_i(t_i), .v_o(v_o)
  );

  // {req[7:0], v[14:0], t[14:0], en, pre, dot[8:0], expected[14:0]}
  localparam int NV = 24;
  localparam logic [63:0] VEC [NV] = '{
    {8'd9, 15'h1234, 15'h7FFF, 1'b1, 1'b0, 9'd100, 15'h1234}, // R9 idle dot
    {8'd3, 15'h0003, 15'h0000, 1'b1, 1'b0, 9'd8,   15'h0004}, // R3 step
    {8'd3, 15'h001F, 15'h0000, 1'b1, 1'b0, 9'd16,  15'h0400}, // R3 wrap sets nt_h
    {8'd3, 15'h041F, 15'h0000, 1'b1, 1'b0, 9'd336, 15'h0000}, // R3 wrap clears nt_h
    {8'd3, 15'h0005, 15'h0000, 1'b1, 1'b0, 9'd328, 15'h0006}, // R3 prefetch window
    {8'd3, 15'h0005, 15'h0000, 1'b1, 1'b0, 9'd264, 15'h0005}, // R3 outside windows
    {8'd3, 15'h0005, 15'h0000, 1'b1, 1'b0, 9'd320, 15'h0005}, // R3 just before window
    {8'd4, 15'h20A0, 15'h0000, 1'b1, 1'b0, 9'd250, 15'h30A0}, // R4 fine step
    {8'd4, 15'h7080, 15'h0000, 1'b1, 1'b0, 9'd250, 15'h00A0}, // R4 fine rollover
    {8'd5, 15'h73A0, 15'h0000, 1'b1, 1'b0, 9'd250, 15'h0800}, // R5 row 29
    {8'd5, 15'h7BA0, 15'h0000, 1'b1, 1'b0, 9'd250, 15'h0000}, // R5 row 29, nt_v set
    {8'd6, 15'h73E0, 15'h0000, 1'b1, 1'b0, 9'd250, 15'h0000}, // R6 row 31
    {8'd6, 15'h7BE0, 15'h0000, 1'b1, 1'b0, 9'd250, 15'h0800}, // R6 row 31 keeps nt_v
    {8'd6, 15'h73C0, 15'h0000, 1'b1, 1'b0, 9'd250, 15'h03E0}, // R6 row 30
    {8'd7, 15'h5A5A, 15'h25A5, 1'b1, 1'b0, 9'd256, 15'h5E45}, // R7 horizontal copy
    {8'd7, 15'h5A5A, 15'h25A5, 1'b1, 1'b1, 9'd256, 15'h5E45}, // R7 on pre-render
    {8'd7, 15'h001F, 15'h0000, 1'b1, 1'b0, 9'd256, 15'h0000}, // R7 copy beats step
    {8'd8, 15'h1111, 15'h6543, 1'b1, 1'b1, 9'd304, 15'h6543}, // R8 full copy
    {8'd8, 15'h1111, 15'h6543, 1'b1, 1'b0, 9'd304, 15'h1111}, // R8 not pre-render
    {8'd4, 15'h1000, 15'h0000, 1'b1, 1'b1, 9'd250, 15'h2000}, // R4 on pre-render
    {8'd2, 15'h1111, 15'h6543, 1'b0, 1'b1, 9'd304, 15'h1111}, // R2 no full copy
    {8'd2, 15'h73A0, 15'h0000, 1'b0, 1'b0, 9'd250, 15'h73A0}, // R2 no vertical
    {8'd2, 15'h001F, 15'h0000, 1'b0, 1'b0, 9'd8,   15'h001F}, // R2 no tile step
    {8'd2, 15'h5A5A, 15'h25A5, 1'b0, 1'b0, 9'd256, 15'h5A5A}  // R2 no h copy
  };

  task automatic check(input int req, input logic [14:0] exp);
    checks++;
    if (v_o !== exp) begin
      errors++;
      $display("FAIL R%0d: v_o=%h expected=%h", req, v_o, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    v_i = 15'h7FFF; t_i = 15'h7FFF; render_en_i = 1'b1; prerender_i = 1'b1; dot_i = 9'd304;
    @(negedge clk_i);
    check(1, 15'h0000); // R1 held in reset
    @(negedge clk_i);
    rst_ni = 1'b1;
    render_en_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      v_i         = VEC[i][55:41];
      t_i         = VEC[i][40:26];
      render_en_i = VEC[i][25];
      prerender_i = VEC[i][24];
      dot_i       = VEC[i][23:15];
      @(negedge clk_i);
      check(int'(VEC[i][63:56]), VEC[i][14:0]);
    end

    // R9 sweep of idle dots keeps vertical fields
    for (int d = 257; d < 304; d++) begin
      @(negedge clk_i);
      v_i = 15'h6BC3; render_en_i = 1'b1; prerender_i = 1'b0; dot_i = 9'(d);
      @(negedge clk_i);
      checks++;
      if (v_o[14:11] !== 4'hD || v_o[9:5] !== 5'h1E) begin
        errors++;
        $display("FAIL R9: dot %0d v_o=%h expected upper=%h", d, v_o, 15'h6BC3);
      end
    end

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    v_i = 15'h1234; dot_i = 9'd100;
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1 check(1, 15'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(9, 15'h1234); // R9 resumes after reset
    finish_run();
  end
endmodule